// File: doc/BRIEF.md
# Effective Address Generator

This block turns an addressing-mode code plus the operand bytes of an instruction into the 24-bit effective address used by a 16-bit processor with separate data and program bank registers. It also reports how far the program counter moves past the operand bytes and how many extra internal cycles the mode costs. A request is made by pulsing `start` with the mode, the operand bytes (first byte in bits 7:0, second in 15:8, third in 23:16), the address of the first operand byte on `pc`, and the register file values.

Direct, absolute, long, relative and stack modes are pure arithmetic. Each has its own wrap rule and finishes one cycle after `start`. Indirect modes first form a pointer address. They then read a 2-byte or 3-byte little-endian pointer through a byte-wide request/valid read port, one byte per beat. They combine the pointer with a bank register or the Y index and finish one cycle after the last beat. All register and operand inputs are sampled only in the cycle `start` is accepted.

Top module: `eaddr_unit`

## Requirements
- R1: Modes 0 (direct), 1 (direct+X) and 2 (direct+Y) give {8'h00, (operand byte + D [+X or Y]) mod 2^16}. They report pc_inc 1, xcyc 0 for mode 0 and xcyc 1 for modes 1 and 2.
- R2: Mode 3 (absolute) gives {DB, operand word}. Modes 4 and 5 add X or Y to that 24-bit value so that a carry enters the bank byte. All three report pc_inc 2 and xcyc 0.
- R3: Mode 6 (long) gives the 3 operand bytes as the address. Mode 7 adds X modulo 2^24. Both report pc_inc 3 and xcyc 0.
- R4: Mode 8 (relative) gives (pc + 1 + sign-extended operand byte) mod 2^16 with pc_inc 1. Mode 9 (relative long) gives (pc + 2 + operand word) mod 2^16 with pc_inc 2. Both report xcyc 0.
- R5: Mode 18 (stack relative) gives (operand byte + S) mod 2^16 with xcyc 1. Mode 19 reads a word at that address and gives (DB·2^16 + word + Y) mod 2^24 with xcyc 2. Both report pc_inc 1.
- R6: Mode 10 reads a word at bank 0, operand word, and gives {PB, word}. Mode 11 reads at {PB, (operand word + X) mod 2^16} and gives {PB, word}. Mode 12 reads 3 bytes at bank 0, operand word, and gives that 24-bit value. All three report pc_inc 2. Modes 10 and 11 report xcyc 0, and mode 12 reports xcyc 0.
- R7: Pointer modes on direct page report pc_inc 1 and xcyc 0, except mode 14 (xcyc 1). Their pointer address is {8'h00, (byte + D) mod 2^16}, or for mode 14 {8'h00, (byte + D + X) mod 2^16}. Modes 13 and 14 give {DB, word}. Mode 15 gives the 3-byte pointer. Mode 16 gives (DB·2^16 + word + Y) mod 2^24. Mode 17 gives (pointer + Y) mod 2^24.
- R8: Every valid mode reports a nonzero pc_inc, and xcyc never exceeds 2.
- R9: A pointer read issues beat k at (pointer address + k) mod 2^24, lowest byte first. mem_req stays high with mem_addr unchanged until mem_valid, and each valid accepts exactly one byte.
- R10: done pulses one cycle after an accepted start for non-pointer modes, and one cycle after the final beat for pointer modes. A start while a pointer read is in progress is ignored. Register changes after the accepted start do not affect the result.
- R11: Mode codes 20 to 31 give ea 0, err 1, pc_inc 0 and xcyc 0, with done one cycle after start.
- R12: During reset done, err, mem_req and ea are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new address computation |
| mode | input | 5 | Addressing-mode code |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| pc | input | 16 | Address of the first operand byte |
| dp | input | 16 | Direct-page base register |
| sp | input | 16 | Stack pointer |
| xr | input | 16 | X index register |
| yr | input | 16 | Y index register |
| dbank | input | 8 | Data bank register |
| pbank | input | 8 | Program bank register |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_rdata | input | 8 | Read data byte |
| mem_valid | input | 1 | Read data valid, completes one beat |
| ea | output | 24 | Effective address, held until the next result |
| pc_inc | output | 2 | Program counter advance past the operand bytes |
| xcyc | output | 2 | Extra internal cycles for the mode |
| err | output | 1 | Mode code was unused |
| done | output | 1 | Result valid pulse |

## Verification
The hardest case to reach is a second request arriving while a pointer read is stalled, together with register values changing underneath it. The bench holds back mem_valid for several cycles. During that stall it pulses start with a different mode and flips the data bank and Y inputs. It then checks that the pointer beats, the final address and the single done pulse all follow the original request. The wrap corners are driven with values chosen to land exactly on them: pointer words that straddle a bank boundary, direct sums past 0xFFFF, and absolute-indexed carries into the bank.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

  typedef enum logic [4:0] {
    M_DIR    = 5'd0,
    M_DIRX   = 5'd1,
    M_DIRY   = 5'd2,
    M_ABS    = 5'd3,
    M_ABSX   = 5'd4,
    M_ABSY   = 5'd5,
    M_LONG   = 5'd6,
    M_LONGX  = 5'd7,
    M_REL    = 5'd8,
    M_RELL   = 5'd9,
    M_AIND   = 5'd10,
    M_AXIND  = 5'd11,
    M_AINDL  = 5'd12,
    M_DIND   = 5'd13,
    M_DXIND  = 5'd14,
    M_DINDL  = 5'd15,
    M_DINDY  = 5'd16,
    M_DINDLY = 5'd17,
    M_STK    = 5'd18,
    M_STKY   = 5'd19
  } ea_mode_e;

endpackage

// File: rtl/eaddr_calc.sv
module eaddr_calc
  import eaddr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = WORD_W + BANK_W
) (
  input  logic [4:0]        mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] dp,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] xr,
  input  logic [WORD_W-1:0] yr,
  input  logic [BANK_W-1:0] dbank,
  input  logic [BANK_W-1:0] pbank,
  output logic [ADDR_W-1:0] lin_ea,
  output logic [ADDR_W-1:0] ptr_base,
  output logic              ind,
  output logic              ptr3,
  output logic [1:0]        inc,
  output logic [1:0]        xc,
  output logic              bad
);
  localparam int BYTE_W = 8;

  logic [WORD_W-1:0] op8, op16, dsum, dxs, dys, ssum, axs, rel8, rel16;
  logic [ADDR_W-1:0] absv;

  always_comb begin
    op8   = WORD_W'(opnd[BYTE_W-1:0]);
    op16  = opnd[WORD_W-1:0];
    dsum  = op8 + dp;
    dxs   = dsum + xr;
    dys   = dsum + yr;
    ssum  = op8 + sp;
    axs   = op16 + xr;
    rel8  = pc + WORD_W'(1) + {{(WORD_W-BYTE_W){opnd[BYTE_W-1]}}, opnd[BYTE_W-1:0]};
    rel16 = pc + WORD_W'(2) + op16;
    absv  = {dbank, op16};
  end

  always_comb begin
    lin_ea   = '0;
    ptr_base = '0;
    ind      = 1'b0;
    ptr3     = 1'b0;
    inc      = 2'd1;
    xc       = 2'd0;
    bad      = 1'b0;
    case (mode)
      M_DIR:    lin_ea = ADDR_W'(dsum);
      M_DIRX:   begin lin_ea = ADDR_W'(dxs); xc = 2'd1; end
      M_DIRY:   begin lin_ea = ADDR_W'(dys); xc = 2'd1; end
      M_ABS:    begin lin_ea = absv; inc = 2'd2; end
      M_ABSX:   begin lin_ea = absv + ADDR_W'(xr); inc = 2'd2; end
      M_ABSY:   begin lin_ea = absv + ADDR_W'(yr); inc = 2'd2; end
      M_LONG:   begin lin_ea = opnd; inc = 2'd3; end
      M_LONGX:  begin lin_ea = opnd + ADDR_W'(xr); inc = 2'd3; end
      M_REL:    lin_ea = ADDR_W'(rel8);
      M_RELL:   begin lin_ea = ADDR_W'(rel16); inc = 2'd2; end
      M_STK:    begin lin_ea = ADDR_W'(ssum); xc = 2'd1; end
      M_AIND:   begin ind = 1'b1; ptr_base = ADDR_W'(op16); inc = 2'd2; end
      M_AXIND:  begin ind = 1'b1; ptr_base = {pbank, axs}; inc = 2'd2; end
      M_AINDL:  begin ind = 1'b1; ptr3 = 1'b1; ptr_base = ADDR_W'(op16); inc = 2'd2; end
      M_DIND:   begin ind = 1'b1; ptr_base = ADDR_W'(dsum); end
      M_DXIND:  begin ind = 1'b1; ptr_base = ADDR_W'(dxs); xc = 2'd1; end
      M_DINDL:  begin ind = 1'b1; ptr3 = 1'b1; ptr_base = ADDR_W'(dsum); end
      M_DINDY:  begin ind = 1'b1; ptr_base = ADDR_W'(dsum); end
      M_DINDLY: begin ind = 1'b1; ptr3 = 1'b1; ptr_base = ADDR_W'(dsum); end
      M_STKY:   begin ind = 1'b1; ptr_base = ADDR_W'(ssum); xc = 2'd2; end
      default:  begin bad = 1'b1; inc = 2'd0; end
    endcase
  end

endmodule

// File: rtl/eaddr_fetch.sv
module eaddr_fetch #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic              three,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              fin,
  output logic [23:0]       ptr
);
  logic              act_q, act_d;
  logic [1:0]        beat_q, beat_d;
  logic              len3_q, len3_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [7:0]        b0_q, b0_d, b1_q, b1_d;
  logic              take, last;

  assign take     = act_q & mem_valid;
  assign last     = len3_q ? (beat_q == 2'd2) : (beat_q == 2'd1);
  assign fin      = take & last;
  assign mem_req  = act_q;
  assign busy     = act_q;
  assign mem_addr = base_q + ADDR_W'(beat_q);
  assign ptr      = len3_q ? {mem_rdata, b1_q, b0_q} : {8'h00, mem_rdata, b0_q};

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    len3_d = len3_q;
    base_d = base_q;
    b0_d   = b0_q;
    b1_d   = b1_q;
    if (go) begin
      act_d  = 1'b1;
      beat_d = 2'd0;
      len3_d = three;
      base_d = base;
    end else if (take) begin
      if (beat_q == 2'd0) b0_d = mem_rdata;
      if (beat_q == 2'd1) b1_d = mem_rdata;
      beat_d = beat_q + 2'd1;
      if (last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= 2'd0;
      len3_q <= 1'b0;
      base_q <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
    end else if (go || take) begin
      act_q  <= act_d;
      beat_q <= beat_d;
      len3_q <= len3_d;
      base_q <= base_d;
      b0_q   <= b0_d;
      b1_q   <= b1_d;
    end
  end

endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
  import eaddr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = WORD_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4:0]        mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] dp,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] xr,
  input  logic [WORD_W-1:0] yr,
  input  logic [BANK_W-1:0] dbank,
  input  logic [BANK_W-1:0] pbank,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic [ADDR_W-1:0] ea,
  output logic [1:0]        pc_inc,
  output logic [1:0]        xcyc,
  output logic              err,
  output logic              done
);
  logic [ADDR_W-1:0] lin_ea, ptr_base, fin_ea;
  logic              ind, ptr3, bad, busy, fin, accept;
  logic [1:0]        inc, xc;
  logic [23:0]       ptr;

  logic [4:0]        md_q;
  logic [BANK_W-1:0] db_q, pb_q;
  logic [WORD_W-1:0] y_q;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              done_q, done_d, err_q;
  logic [1:0]        inc_q, xc_q;

  eaddr_calc #(.WORD_W(WORD_W), .BANK_W(BANK_W)) u_calc (
    .mode(mode), .opnd(opnd), .pc(pc), .dp(dp), .sp(sp), .xr(xr), .yr(yr),
    .dbank(dbank), .pbank(pbank), .lin_ea(lin_ea), .ptr_base(ptr_base),
    .ind(ind), .ptr3(ptr3), .inc(inc), .xc(xc), .bad(bad)
  );

  assign accept = start & ~busy;

  eaddr_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(accept & ind), .base(ptr_base), .three(ptr3),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .fin(fin), .ptr(ptr)
  );

  // combine the fetched pointer with the bank or index sampled at start
  always_comb begin
    case (md_q)
      M_AIND, M_AXIND: fin_ea = {pb_q, ptr[WORD_W-1:0]};
      M_DIND, M_DXIND: fin_ea = {db_q, ptr[WORD_W-1:0]};
      M_DINDY, M_STKY: fin_ea = {db_q, ptr[WORD_W-1:0]} + ADDR_W'(y_q);
      M_DINDLY:        fin_ea = ADDR_W'(ptr) + ADDR_W'(y_q);
      default:         fin_ea = ADDR_W'(ptr);
    endcase
  end

  always_comb begin
    done_d = (accept & ~ind) | fin;
    ea_d   = ea_q;
    if (accept & ~ind) ea_d = lin_ea;
    else if (fin)      ea_d = fin_ea;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ea_q   <= '0;
    end else begin
      done_q <= done_d;
      ea_q   <= ea_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_q  <= '0;
      db_q  <= '0;
      pb_q  <= '0;
      y_q   <= '0;
      err_q <= 1'b0;
      inc_q <= '0;
      xc_q  <= '0;
    end else if (accept) begin
      md_q  <= mode;
      db_q  <= dbank;
      pb_q  <= pbank;
      y_q   <= yr;
      err_q <= bad;
      inc_q <= inc;
      xc_q  <= xc;
    end
  end

  assign ea     = ea_q;
  assign done   = done_q;
  assign err    = err_q;
  assign pc_inc = inc_q;
  assign xcyc   = xc_q;

endmodule

// File: rtl/eaddr_unit_chk.sv
module eaddr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [23:0] mem_addr,
  input logic        mem_valid,
  input logic [23:0] ea,
  input logic [1:0]  pc_inc,
  input logic [1:0]  xcyc,
  input logic        err,
  input logic        done
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R10
  done_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R11
  bad_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> ea == 24'h0 && pc_inc == 2'd0 && xcyc == 2'd0);

  // R8
  pc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> pc_inc != 2'd0);

  // R8
  xcyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> xcyc != 2'd3);
endmodule

bind eaddr_unit eaddr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .ea(ea), .pc_inc(pc_inc), .xcyc(xcyc),
  .err(err), .done(done)
);

// File: tb/eaddr_unit_test.sv
module eaddr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n, start, mem_valid;
  logic [4:0]  mode;
  logic [23:0] opnd;
  logic [15:0] pc, dp, sp, xr, yr;
  logic [7:0]  dbank, pbank, mem_rdata;
  logic        mem_req, err, done;
  logic [23:0] mem_addr, ea;
  logic [1:0]  pc_inc, xcyc;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eaddr_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd(opnd),
    .pc(pc), .dp(dp), .sp(sp), .xr(xr), .yr(yr), .dbank(dbank), .pbank(pbank),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .ea(ea), .pc_inc(pc_inc), .xcyc(xcyc),
    .err(err), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int memb(input int a);
    return (a * 7 + (a >> 8) * 13 + (a >> 16) * 29) & 255;
  endfunction

  // reference model of the requirements
  function automatic void ref_mode(input int m, input int op, input int p, input int d,
      input int s, input int x, input int db, input int pb,
      output int lin, output int base, output int n, output int inc, output int xc,
      output int bad);
    int b0, w, s8;
    b0 = op & 255; w = op & 16'hFFFF;
    s8 = (b0 >= 128) ? b0 - 256 : b0;
    lin = 0; base = 0; n = 0; inc = 1; xc = 0; bad = 0;
    case (m)
      0:  lin = (b0 + d) & 16'hFFFF;
      1:  begin lin = (b0 + d + x) & 16'hFFFF; xc = 1; end
      2:  begin lin = (b0 + d + yr) & 16'hFFFF; xc = 1; end
      3:  begin lin = db * 65536 + w; inc = 2; end
      4:  begin lin = (db * 65536 + w + x) & 24'hFFFFFF; inc = 2; end
      5:  begin lin = (db * 65536 + w + yr) & 24'hFFFFFF; inc = 2; end
      6:  begin lin = op; inc = 3; end
      7:  begin lin = (op + x) & 24'hFFFFFF; inc = 3; end
      8:  lin = (p + 1 + s8) & 16'hFFFF;
      9:  begin lin = (p + 2 + w) & 16'hFFFF; inc = 2; end
      10: begin base = w; n = 2; inc = 2; end
      11: begin base = pb * 65536 + ((w + x) & 16'hFFFF); n = 2; inc = 2; end
      12: begin base = w; n = 3; inc = 2; end
      13, 16: begin base = (b0 + d) & 16'hFFFF; n = 2; end
      14: begin base = (b0 + d + x) & 16'hFFFF; n = 2; xc = 1; end
      15, 17: begin base = (b0 + d) & 16'hFFFF; n = 3; end
      18: begin lin = (b0 + s) & 16'hFFFF; xc = 1; end
      19: begin base = (b0 + s) & 16'hFFFF; n = 2; xc = 2; end
      default: begin bad = 1; inc = 0; end
    endcase
  endfunction

  function automatic int ref_final(input int m, input int ptrv, input int db, input int pb,
                                   input int y);
    int w;
    w = ptrv & 16'hFFFF;
    case (m)
      10, 11: return pb * 65536 + w;
      13, 14: return db * 65536 + w;
      16, 19: return (db * 65536 + w + y) & 24'hFFFFFF;
      17:     return (ptrv + y) & 24'hFFFFFF;
      default: return ptrv;
    endcase
  endfunction

  task automatic setr(input int p, input int d, input int s, input int x, input int y,
                      input int db, input int pb);
    pc = 16'(p); dp = 16'(d); sp = 16'(s); xr = 16'(x); yr = 16'(y);
    dbank = 8'(db); pbank = 8'(pb);
  endtask

  // one request; lat = wait cycles before each valid; intr = disturb during the stall
  task automatic run(input string req, input int m, input int op, input int lat, input bit intr);
    int lin, base, n, inc, xc, bad, ptrv, expv, db0, pb0, y0, a;
    db0 = dbank; pb0 = pbank; y0 = yr;
    ref_mode(m, op, pc, dp, sp, xr, dbank, pbank, lin, base, n, inc, xc, bad);
    @(negedge clk);
    mode = 5'(m); opnd = 24'(op); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(bad ? "R11" : req, "done", done, 1);
      expv = lin;
    end else begin
      ptrv = 0;
      for (int k = 0; k < n; k++) begin
        a = (base + k) & 24'hFFFFFF;
        chk("R10", "done during fetch", done, 0);
        chk("R9", "mem_req", mem_req, 1);
        chk("R9", "beat address", mem_addr, a);
        for (int w = 0; w < lat; w++) begin
          if (intr && k == 0 && w == 0) begin
            start = 1'b1; mode = 5'd0; dbank = ~dbank; yr = ~yr; pbank = ~pbank;
          end
          @(negedge clk);
          start = 1'b0;
          chk("R9", "req held", mem_req, 1);
          chk("R9", "addr held", mem_addr, a);
          chk("R10", "no done while stalled", done, 0);
        end
        mem_valid = 1'b1; mem_rdata = 8'(memb(a));
        ptrv = ptrv | (memb(a) << (8 * k));
        @(negedge clk);
        mem_valid = 1'b0;
      end
      chk(req, "done after last beat", done, 1);
      chk("R9", "req dropped", mem_req, 0);
      expv = ref_final(m, ptrv, db0, pb0, y0);
    end
    chk(req, "ea", ea, expv);
    chk(bad ? "R11" : "R8", "pc_inc", pc_inc, inc);
    chk(bad ? "R11" : req, "xcyc", xcyc, xc);
    chk("R11", "err", err, bad);
    @(negedge clk);
    chk("R10", "done is one pulse", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_valid = 1'b0; mem_rdata = '0;
    mode = '0; opnd = '0; setr(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12", "reset done", done, 0);
    chk("R12", "reset mem_req", mem_req, 0);
    chk("R12", "reset ea", ea, 0);
    chk("R12", "reset err", err, 0);
    rst_n = 1'b1;

    setr(16'h4000, 16'h1200, 16'h01F0, 16'h0005, 16'h0007, 8'h7E, 8'h01);
    run("R1", 0, 24'h000034, 0, 0);
    setr(16'h4000, 16'hFFF0, 16'h01F0, 16'h0005, 16'h0009, 8'h7E, 8'h01);
    run("R1", 0, 24'h000020, 0, 0);
    run("R1", 1, 24'h000010, 0, 0);
    run("R1", 2, 24'h000010, 0, 0);
    setr(16'h4000, 16'h0000, 16'h01F0, 16'h0020, 16'h0030, 8'h12, 8'h01);
    run("R2", 3, 24'h001234, 0, 0);
    run("R2", 4, 24'h00FFF0, 0, 0);
    run("R2", 5, 24'h00FFE0, 0, 0);
    run("R3", 6, 24'hABCDEF, 0, 0);
    run("R3", 7, 24'hFFFFF0, 0, 0);
    setr(16'h1000, 16'h0000, 16'h01F0, 16'h0000, 16'h0000, 8'h12, 8'h01);
    run("R4", 8, 24'h000080, 0, 0);
    run("R4", 8, 24'h00007F, 0, 0);
    setr(16'hFFFF, 16'h0000, 16'h01F0, 16'h0000, 16'h0000, 8'h12, 8'h01);
    run("R4", 8, 24'h000005, 0, 0);
    setr(16'hFFF0, 16'h0000, 16'h01F0, 16'h0000, 16'h0000, 8'h12, 8'h01);
    run("R4", 9, 24'h000020, 0, 0);
    setr(16'h2000, 16'h0300, 16'hFFF8, 16'h0002, 16'hFFFF, 8'hFF, 8'h05);
    run("R5", 18, 24'h000010, 0, 0);
    run("R5", 19, 24'h000003, 1, 0);
    run("R6", 10, 24'h008000, 0, 0);
    run("R6", 11, 24'h00FFFF, 3, 1);
    run("R6", 12, 24'h00FFFF, 2, 0);
    run("R7", 13, 24'h000044, 0, 0);
    setr(16'h2000, 16'hFFF0, 16'h01F0, 16'h000F, 16'hF000, 8'hC0, 8'h05);
    run("R7", 14, 24'h000001, 2, 1);
    run("R7", 15, 24'h000010, 1, 0);
    run("R7", 16, 24'h00000F, 0, 0);
    run("R7", 17, 24'h00000E, 2, 1);
    run("R11", 20, 24'h123456, 0, 0);
    run("R11", 31, 24'hFFFFFF, 0, 0);
    run("R1", 0, 24'h000001, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule